// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block counts hardware events for a processor cluster. It holds a parameterized number of 32-bit event counters and one free-running 64-bit cycle counter. Each event counter takes its input from one of 64 event lines. The line is chosen by an 8-bit event code. Two codes are special. One counts every clock. The other chains an odd counter onto the wraps of the counter just below it, so that the pair forms a wider count.

Software reaches the block through a synchronous word-addressed register port. A write takes effect at the clock edge. Read data is combinational from the address, and a read strobe gives side effects at the edge. Each counter has its own count-enable and its own interrupt-enable, and both can be set or cleared without touching the others. A wrap of any counter raises a sticky overflow flag. A read of the status word clears that flag. While an enabled flag is set, a level interrupt stays high.

Top module: `cluster_pmu`

## Requirements
- R1: Control word (address 0) bit 0 is the global enable. While it is 0, no event counter and not the cycle counter advances, whatever the per-counter enables hold.
- R2: Writing 1 to control bit 1 zeroes every event counter. Writing 1 to control bit 2 zeroes the cycle counter. Both bits read 0. Control bits [15:11] read the number of event counters, [23:16] an ID code and [31:24] an implementer code, and writes do not change these fields.
- R3: Every bitmap places event counter n at bit n and the cycle counter at bit 31. Bits with no counter read 0. Address 1 sets count-enables and address 2 clears them. Address 3 sets interrupt-enables and address 4 clears them. In all four, a 1 in the write data acts on that bit, and a read returns the current mask.
- R4: An enabled event counter adds 1 at each clock edge where its source is high. Event code 0x11 makes the counter advance every clock. A code below 0x40 picks event line `code`. Any other code counts nothing. The code is held in bits [7:0] of the type window.
- R5: Code 0x1e on an odd counter n counts the wraps of counter n-1 in the same clock. On an even counter, code 0x1e counts nothing.
- R6: The 64-bit cycle counter is read and written as a low half at address 9 and a high half at address 10. A write to one half leaves the other half unchanged. It advances every clock while bit 31 is enabled.
- R7: A counter that steps from all ones to zero sets its overflow bit at that same edge. A software write or zeroing action in the same cycle as an increment wins, and then neither the increment nor an overflow happens.
- R8: A read of address 5 returns the overflow bits and clears them at that edge. An overflow that arises in the same cycle as the read stays set. Writes to address 5 are ignored.
- R9: The `irq` output is high exactly while some counter has both its overflow bit and its interrupt-enable bit set.
- R10: Address 6 bits [4:0] select the event counter that the value window (address 7) and the type window (address 8) access. A select value at or beyond the counter count makes both windows read 0 and ignore writes.
- R11: Addresses 11 and 12 read a fixed map of supported event codes: codes 0 to 31 at address 11 and codes 32 to 63 at address 12, with code k at bit k mod 32. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the read side effects) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 64 | Event lines, one per event code below 0x40 |
| irq | output | 1 | Level interrupt on an enabled overflow |

## Verification
The assertions check four behaviours on every cycle. Counters stay frozen while the global enable is off. Every wrap leaves its overflow flag set on the next cycle. A status read with no new wrap leaves the status empty. The interrupt drops only after a status read or an interrupt-enable clear. The bench's scenarios are needed to show the counting sources in detail: line selection, the every-clock code, chaining from even to odd counters, and that codes out of range do nothing. They are also needed for write-over-increment priority, for the select window beyond range, and for the overflow of the 64-bit cycle counter. A behavioural model runs alongside the design, and a random phase mixes all register operations with random event traffic.

// File: rtl/cluster_pmu.sv
module cluster_pmu #(
  parameter int          NUM_EVT   = 6,
  parameter logic [7:0]  ID_CODE   = 8'h2a,
  parameter logic [7:0]  IMPL_CODE = 8'h5c,
  parameter logic [63:0] SUPPORT   = 64'h0000_0003_e202_0821
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [63:0] evt_in,
  output logic        irq
);
  localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2, A_IES = 4'd3,
                         A_IEC = 4'd4, A_OVF = 4'd5, A_SEL = 4'd6, A_VAL = 4'd7,
                         A_TYP = 4'd8, A_CYL = 4'd9, A_CYH = 4'd10, A_SP0 = 4'd11,
                         A_SP1 = 4'd12;
  localparam logic [31:0] VMASK = ((32'd1 << NUM_EVT) - 32'd1) | 32'h8000_0000;
  localparam logic [7:0]  EV_CYC = 8'h11, EV_CHAIN = 8'h1e;

  logic        gen_en;
  logic [31:0] cnt_en, int_en, ovf, new_ovf;
  logic [4:0]  sel;
  logic [63:0] cyc;
  logic [NUM_EVT-1:0] wrap_v;
  logic [31:0] cnt_q [NUM_EVT];
  logic [7:0]  code_q [NUM_EVT];

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire p_clr    = wr_ctrl && reg_wdata[1];
  wire c_clr    = wr_ctrl && reg_wdata[2];
  wire sel_ok   = sel < 5'(NUM_EVT);
  wire ovf_read = reg_rd && reg_addr == A_OVF;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_ctr
    logic [31:0] val;
    logic [7:0]  code;
    logic        link, src, hit, wr_val, wrap;
    if (i % 2 == 1) begin : g_odd
      assign link = g_ctr[i-1].wrap;
    end else begin : g_even
      assign link = 1'b0;
    end
    assign src    = (code == EV_CYC) ? 1'b1 :
                    (code == EV_CHAIN) ? link :
                    (code[7:6] == 2'b00) ? evt_in[code[5:0]] : 1'b0;
    assign hit    = gen_en && cnt_en[i] && src;
    assign wr_val = reg_wr && reg_addr == A_VAL && sel == 5'(i);
    assign wrap   = hit && (&val) && !wr_val && !p_clr;
    assign wrap_v[i] = wrap;
    assign cnt_q[i]  = val;
    assign code_q[i] = code;

    always_ff @(posedge clk) begin
      if (rst) begin
        val  <= '0;
        code <= '0;
      end else begin
        if (p_clr)       val <= '0;
        else if (wr_val) val <= reg_wdata;
        else if (hit)    val <= val + 32'd1;
        if (reg_wr && reg_addr == A_TYP && sel == 5'(i)) code <= reg_wdata[7:0];
      end
    end

    assert_frozen_R1: assert property (@(posedge clk) disable iff (rst)
      (!gen_en && !reg_wr) |=> $stable(val));
    assert_wrap_flag_R7: assert property (@(posedge clk) disable iff (rst)
      wrap |=> ovf[i]);
    assert_pzero_R2: assert property (@(posedge clk) disable iff (rst)
      p_clr |=> (val == 32'd0));
  end

  wire cyc_hit  = gen_en && cnt_en[31];
  wire cyc_wr   = reg_wr && (reg_addr == A_CYL || reg_addr == A_CYH);
  wire cyc_wrap = cyc_hit && (&cyc) && !cyc_wr && !c_clr;

  always_comb begin
    new_ovf = '0;
    new_ovf[NUM_EVT-1:0] = wrap_v;
    new_ovf[31] = cyc_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en <= 1'b0;
      cnt_en <= '0;
      int_en <= '0;
      ovf    <= '0;
      sel    <= '0;
      cyc    <= '0;
    end else begin
      ovf <= (ovf_read ? 32'd0 : ovf) | new_ovf;
      if (c_clr)                              cyc <= '0;
      else if (reg_wr && reg_addr == A_CYL)   cyc <= {cyc[63:32], reg_wdata};
      else if (reg_wr && reg_addr == A_CYH)   cyc <= {reg_wdata, cyc[31:0]};
      else if (cyc_hit)                       cyc <= cyc + 64'd1;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: gen_en <= reg_wdata[0];
          A_ENS:  cnt_en <= cnt_en | (reg_wdata & VMASK);
          A_ENC:  cnt_en <= cnt_en & ~(reg_wdata & VMASK);
          A_IES:  int_en <= int_en | (reg_wdata & VMASK);
          A_IEC:  int_en <= int_en & ~(reg_wdata & VMASK);
          A_SEL:  sel    <= reg_wdata[4:0];
          default: ;
        endcase
      end
    end
  end

  assign irq = |(ovf & int_en);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {IMPL_CODE, ID_CODE, 5'(NUM_EVT), 10'd0, gen_en};
      A_ENS, A_ENC: reg_rdata = cnt_en;
      A_IES, A_IEC: reg_rdata = int_en;
      A_OVF:   reg_rdata = ovf;
      A_SEL:   reg_rdata = {27'd0, sel};
      A_VAL:   reg_rdata = sel_ok ? cnt_q[sel] : 32'd0;
      A_TYP:   reg_rdata = sel_ok ? {24'd0, code_q[sel]} : 32'd0;
      A_CYL:   reg_rdata = cyc[31:0];
      A_CYH:   reg_rdata = cyc[63:32];
      A_SP0:   reg_rdata = SUPPORT[31:0];
      A_SP1:   reg_rdata = SUPPORT[63:32];
      default: reg_rdata = 32'd0;
    endcase
  end

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf_read && new_ovf == 32'd0) |=> (ovf == 32'd0));
  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(ovf_read) || $past(reg_wr && reg_addr == A_IEC)));
  assert_cyc_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    (!gen_en && !reg_wr) |=> $stable(cyc));
endmodule

// File: tb/sim_cluster_pmu.sv
module sim_cluster_pmu;
  localparam int          NEV  = 6;
  localparam logic [7:0]  IDC  = 8'h2a;
  localparam logic [7:0]  IMPC = 8'h5c;
  localparam logic [63:0] SUP  = 64'h0000_0003_e202_0821;
  localparam logic [31:0] VM   = ((32'd1 << NEV) - 32'd1) | 32'h8000_0000;

  logic clk = 0, rst = 1, reg_wr = 0, reg_rd = 0, irq;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [63:0] evt_in = 0;
  int total = 0, bad = 0;
  bit done = 0;

  cluster_pmu #(.NUM_EVT(NEV), .ID_CODE(IDC), .IMPL_CODE(IMPC), .SUPPORT(SUP)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq));

  always #5 clk = ~clk;

  bit [31:0] mc [NEV];
  bit [7:0]  mcode [NEV];
  bit [63:0] mcyc;
  bit [31:0] men, mie, movf;
  bit [4:0]  msel;
  bit        mgen;

  function automatic string req_for(input logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1, 4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R8";
      4'd6, 4'd7, 4'd8: return "R10";
      4'd9, 4'd10: return "R6";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] m_rd(input logic [3:0] a);
    case (a)
      4'd0: return {IMPC, IDC, 5'(NEV), 10'd0, mgen};
      4'd1, 4'd2: return men;
      4'd3, 4'd4: return mie;
      4'd5: return movf;
      4'd6: return {27'd0, msel};
      4'd7: return (int'(msel) < NEV) ? mc[msel] : 32'd0;
      4'd8: return (int'(msel) < NEV) ? {24'd0, mcode[msel]} : 32'd0;
      4'd9: return mcyc[31:0];
      4'd10: return mcyc[63:32];
      4'd11: return SUP[31:0];
      4'd12: return SUP[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_update(input bit w, input bit r, input logic [3:0] a,
                          input logic [31:0] d, input logic [63:0] e);
    bit [31:0] nb = 0;
    bit wr_prev = 0;
    bit pclr = w && a == 4'd0 && d[1];
    bit cclr = w && a == 4'd0 && d[2];
    bit hitc, wrc;
    for (int i = 0; i < NEV; i++) begin
      bit src, hit, wrt, wp;
      if (mcode[i] == 8'h11) src = 1;
      else if (mcode[i] == 8'h1e) src = (i % 2 == 1) ? wr_prev : 1'b0;
      else if (mcode[i] < 8'h40) src = e[mcode[i][5:0]];
      else src = 0;
      hit = mgen && men[i] && src;
      wrt = w && a == 4'd7 && int'(msel) == i;
      wp  = hit && mc[i] == 32'hffff_ffff && !wrt && !pclr;
      nb[i] = wp;
      wr_prev = wp;
      if (pclr) mc[i] = 0;
      else if (wrt) mc[i] = d;
      else if (hit) mc[i] = mc[i] + 1;
    end
    hitc = mgen && men[31];
    wrc  = w && (a == 4'd9 || a == 4'd10);
    nb[31] = hitc && mcyc == 64'hffff_ffff_ffff_ffff && !wrc && !cclr;
    if (cclr) mcyc = 0;
    else if (w && a == 4'd9) mcyc[31:0] = d;
    else if (w && a == 4'd10) mcyc[63:32] = d;
    else if (hitc) mcyc = mcyc + 1;
    movf = ((r && a == 4'd5) ? 32'd0 : movf) | nb;
    if (w) begin
      case (a)
        4'd0: mgen = d[0];
        4'd1: men = men | (d & VM);
        4'd2: men = men & ~(d & VM);
        4'd3: mie = mie | (d & VM);
        4'd4: mie = mie & ~(d & VM);
        4'd6: msel = d[4:0];
        4'd8: if (int'(msel) < NEV) mcode[msel] = d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [3:0] a,
                      input logic [31:0] d, input logic [63:0] e, output logic [31:0] got);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; evt_in = e;
    #1;
    got = reg_rdata;
    chk("R9", {31'd0, irq}, {31'd0, |(movf & mie)});
    if (r) chk(req_for(a), reg_rdata, m_rd(a));
    @(posedge clk);
    m_update(w, r, a, d, e);
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; evt_in = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] g;
    step(1, 0, a, d, 64'd0, g);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] g);
    step(0, 1, a, 32'd0, 64'd0, g);
  endtask

  task automatic idle(input int n, input logic [63:0] e);
    logic [31:0] g;
    for (int k = 0; k < n; k++) step(0, 0, 4'd0, 32'd0, e, g);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    repeat (3) @(negedge clk);
    rst = 0;

    rd(4'd0, g);
    chk("R2 reset control", g, {IMPC, IDC, 5'(NEV), 11'd0});
    rd(4'd1, g); chk("R3 reset enables", g, 32'd0);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);

    wr(4'd6, 0); wr(4'd8, 32'h05);
    wr(4'd6, 1); wr(4'd8, 32'h11);
    wr(4'd6, 2); wr(4'd8, 32'h07);
    wr(4'd6, 3); wr(4'd8, 32'h1e);
    wr(4'd6, 4); wr(4'd8, 32'h1e);
    wr(4'd6, 5); wr(4'd8, 32'h50);
    wr(4'd1, 32'hffff_ffff);
    rd(4'd1, g); chk("R3 enable mask", g, VM);

    idle(4, 64'hffff_ffff_ffff_ffff);
    wr(4'd6, 0);
    rd(4'd7, g); chk("R1 frozen event counter", g, 32'd0);
    rd(4'd9, g); chk("R1 frozen cycle counter", g, 32'd0);

    wr(4'd0, 32'd1);
    idle(3, 64'd1 << 5);
    rd(4'd7, g); chk("R4 line count", g, 32'd3);
    idle(2, 64'hffff_ffff_ffff_ffff);
    wr(4'd6, 5);
    rd(4'd7, g); chk("R4 out-of-range code", g, 32'd0);
    wr(4'd6, 4);
    rd(4'd7, g); chk("R5 even chain idle", g, 32'd0);

    wr(4'd6, 2); wr(4'd7, 32'hffff_ffff);
    wr(4'd6, 3); wr(4'd7, 32'd0);
    wr(4'd3, 32'h4);
    chk("R9 irq quiet before wrap", {31'd0, irq}, 32'd0);
    idle(1, 64'd1 << 7);
    rd(4'd7, g); chk("R5 chained count", g, 32'd1);
    chk("R9 irq on enabled overflow", {31'd0, irq}, 32'd1);
    rd(4'd5, g); chk("R7 overflow bit", g, 32'h4);
    chk("R8 irq after read", {31'd0, irq}, 32'd0);
    rd(4'd5, g); chk("R8 status cleared", g, 32'd0);

    wr(4'd6, 0);
    step(1, 0, 4'd7, 32'h100, 64'd1 << 5, g);
    rd(4'd7, g); chk("R7 write beats increment", g, 32'h100);

    wr(4'd0, 32'h3);
    rd(4'd7, g); chk("R2 event zeroing", g, 32'd0);
    rd(4'd0, g); chk("R2 action bits read 0", g & 32'h6, 32'd0);
    wr(4'd0, 32'h5);
    rd(4'd9, g); chk("R2 cycle zeroing", g, 32'd0);

    wr(4'd9, 32'hffff_fff0); wr(4'd10, 32'hffff_ffff);
    rd(4'd10, g); chk("R6 high half", g, 32'hffff_ffff);
    idle(20, 64'd0);
    rd(4'd5, g); chk("R6 cycle overflow", g & 32'h8000_0000, 32'h8000_0000);

    wr(4'd6, 9); wr(4'd7, 32'h55); wr(4'd8, 32'h07);
    rd(4'd7, g); chk("R10 select beyond value", g, 32'd0);
    rd(4'd8, g); chk("R10 select beyond type", g, 32'd0);
    rd(4'd11, g); chk("R11 support low", g, SUP[31:0]);
    rd(4'd12, g); chk("R11 support high", g, SUP[63:32]);
    rd(4'd14, g); chk("R11 unused address", g, 32'd0);

    for (int k = 0; k < 600; k++) begin
      bit w, r;
      logic [3:0] a;
      logic [31:0] d;
      logic [63:0] e;
      w = ($urandom % 3 == 0);
      r = !w && ($urandom % 2 == 0);
      a = 4'($urandom % 14);
      d = $urandom;
      if ($urandom % 4 == 0) d = 32'hffff_fff0 | (d & 32'hf);
      if (a == 4'd6) d = $urandom % 8;
      if (a == 4'd8) d = ($urandom % 3 == 0) ? 32'h1e : ($urandom % 2 == 0 ? 32'h11 : $urandom % 80);
      if (a == 4'd0) d = {29'd0, ($urandom % 10 == 0), ($urandom % 10 == 0), ($urandom % 5 != 0)};
      e = {$urandom, $urandom};
      step(w, r, a, d, e, d);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule